// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 26-bit virtual byte address into a physical byte address by reading a two-level translation structure held in ordinary memory. A requester presents the virtual address together with the base address of its top-level directory. The walker then issues one 32-bit word read for the directory slot and, if that slot is marked present, a second word read for the slot in the lower table that the directory names. Each walk ends in exactly one of two one-cycle pulses: a translated address, or a fault that tells which level was missing.

Pages are 1 KB and both levels hold 256 four-byte slots, so every table fills exactly one page. A directory slot spans 256 KB of virtual space and a lower-table slot spans one page. The virtual address divides, from the top down, into an 8-bit directory index, an 8-bit table index and a 10-bit byte offset. Every slot uses the same layout: bit 0 is the present flag, bits [31:10] hold a 1 KB-aligned frame or table base, and bits [9:1] are don't-care. The memory port is a one-cycle read strobe with an address, answered by a response-valid pulse that may come after any number of wait cycles. Only one walk is in flight at a time.

Top module: `xlate_walker`

## Requirements
- R1: After a synchronous reset, `req_ready` is 1 and `done_valid`, `fault_valid` and `mem_rd` are 0.
- R2: The first read of a walk is at address `req_dirbase + 4 * vaddr[25:18]`.
- R3: When the directory word has bit 0 set, a second read follows at `{dir[31:10], 10'b0} + 4 * vaddr[17:10]`. This read is issued only after the directory response.
- R4: When the table word has bit 0 set, `done_valid` pulses for one cycle with `done_paddr = {pte[31:10], vaddr[9:0]}`.
- R5: When the directory word has bit 0 clear, the walk ends with a one-cycle `fault_valid` pulse, `fault_level = 0` and `fault_vaddr` equal to the request address. No second read is issued.
- R6: When the table word has bit 0 clear, the walk ends with a one-cycle `fault_valid` pulse, `fault_level = 1` and `fault_vaddr` equal to the request address.
- R7: Bits [9:1] of either word have no effect on the outcome or on the addresses read.
- R8: `done_valid` and `fault_valid` are never high in the same cycle. Every accepted request produces exactly one of them.
- R9: `req_ready` is low from the cycle after a request is accepted until the outcome pulse. Any `req_valid` seen in that time is ignored.
- R10: `mem_rd` is high for exactly one cycle per read. The walker waits any number of cycles for `mem_rsp_valid`.
- R11: A reset in the middle of a walk returns the block to idle. No outcome pulse follows, and a response that arrives later is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle; a request is accepted when both are high |
| req_vaddr | input | 26 | Virtual byte address to translate |
| req_dirbase | input | 32 | Byte address of the directory |
| mem_rd | output | 1 | One-cycle word read strobe |
| mem_addr | output | 32 | Byte address of the word read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data word |
| done_valid | output | 1 | One-cycle pulse: translation succeeded |
| done_paddr | output | 32 | Translated physical byte address |
| fault_valid | output | 1 | One-cycle pulse: translation failed |
| fault_level | output | 1 | 0 = directory slot absent, 1 = table slot absent |
| fault_vaddr | output | 26 | Virtual address of the failed walk |

## Verification
The sequencer's state shows at the ports within one read. If a wait state is left early or skipped, the next strobe lands on the wrong address or the pulse carries data from a stale response. If the present check is inverted or taken at the wrong level, the outcome kind changes and the read count changes with it. A register that is not cleared by reset shows up as a spurious pulse or a stray read in the cycles right after a reset issued mid-walk. Random walks with random memory latency and random don't-care bits are compared against a bench model of the two reads. Directed cases cover all-zero and all-one addresses, long waits, requests held during a walk, and the reset abort.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DIR_RD,
      ST_DIR_WT,
      ST_TBL_RD,
      ST_TBL_WT
   } walk_state_t;

   typedef enum logic {
      LVL_DIR = 1'b0,
      LVL_TBL = 1'b1
   } walk_level_t;
endpackage

// File: rtl/xlate_index.sv
// Splits a virtual address into per-level indices (level 0 = directory,
// taken from the top bits) and the in-page byte offset.
module xlate_index #(
   parameter int IDX_W  = 8,
   parameter int OFS_W  = 10,
   parameter int LEVELS = 2,
   localparam int VA_W  = LEVELS * IDX_W + OFS_W
) (
   input  logic [VA_W-1:0]               vaddr,
   output logic [LEVELS-1:0][IDX_W-1:0]  idx,
   output logic [OFS_W-1:0]              offset
);
   for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
      assign idx[g] = vaddr[OFS_W + (LEVELS-1-g)*IDX_W +: IDX_W];
   end
   assign offset = vaddr[OFS_W-1:0];
endmodule

// File: rtl/xlate_addrgen.sv
// Forms the byte address of a table slot: base of the selected level plus
// index scaled by the slot size.
module xlate_addrgen #(
   parameter int AW          = 32,
   parameter int IDX_W       = 8,
   parameter int OFS_W       = 10,
   parameter int ENTRY_BYTES = 4,
   localparam int FRAME_W    = AW - OFS_W
) (
   input  logic               sel_tbl,
   input  logic [AW-1:0]      dir_base,
   input  logic [FRAME_W-1:0] tbl_frame,
   input  logic [IDX_W-1:0]   dir_idx,
   input  logic [IDX_W-1:0]   tbl_idx,
   output logic [AW-1:0]      addr
);
   localparam int SH = $clog2(ENTRY_BYTES);

   logic [AW-1:0]    base_sel;
   logic [AW-1:0]    off_sel;
   logic [IDX_W-1:0] idx_sel;

   assign base_sel = sel_tbl ? {tbl_frame, {OFS_W{1'b0}}} : dir_base;
   assign idx_sel  = sel_tbl ? tbl_idx : dir_idx;

   if ((ENTRY_BYTES & (ENTRY_BYTES - 1)) == 0) begin : g_shift
      assign off_sel = AW'(idx_sel) << SH;
   end else begin : g_mult
      assign off_sel = AW'(idx_sel) * AW'(ENTRY_BYTES);
   end

   assign addr = base_sel + off_sel;
endmodule

// File: rtl/xlate_walker.sv
module xlate_walker #(
   parameter int IDX_W       = 8,
   parameter int OFS_W       = 10,
   parameter int AW          = 32,
   parameter int DW          = 32,
   parameter int PRESENT_BIT = 0,
   localparam int VA_W       = 2 * IDX_W + OFS_W
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            req_valid,
   output logic            req_ready,
   input  logic [VA_W-1:0] req_vaddr,
   input  logic [AW-1:0]   req_dirbase,
   output logic            mem_rd,
   output logic [AW-1:0]   mem_addr,
   input  logic            mem_rsp_valid,
   input  logic [DW-1:0]   mem_rsp_data,
   output logic            done_valid,
   output logic [AW-1:0]   done_paddr,
   output logic            fault_valid,
   output logic            fault_level,
   output logic [VA_W-1:0] fault_vaddr
);
   import xlate_pkg::*;

   localparam int LEVELS      = 2;
   localparam int FRAME_W     = AW - OFS_W;
   localparam int ENTRY_BYTES = DW / 8;

   walk_state_t                 state_q;
   logic [VA_W-1:0]             va_q;
   logic [AW-1:0]               dbase_q;
   logic [FRAME_W-1:0]          tframe_q;
   logic [LEVELS-1:0][IDX_W-1:0] idx;
   logic [OFS_W-1:0]            ofs;
   logic                        sel_tbl;
   logic                        rsp_present;
   logic [FRAME_W-1:0]          rsp_frame;
   logic                        unused_rsv;

   assign rsp_present = mem_rsp_data[PRESENT_BIT];
   assign rsp_frame   = mem_rsp_data[DW-1 -: FRAME_W];
   assign unused_rsv  = ^mem_rsp_data;

   xlate_index #(
      .IDX_W  (IDX_W),
      .OFS_W  (OFS_W),
      .LEVELS (LEVELS)
   ) u_idx (
      .vaddr  (va_q),
      .idx    (idx),
      .offset (ofs)
   );

   assign sel_tbl = (state_q == ST_TBL_RD);

   xlate_addrgen #(
      .AW          (AW),
      .IDX_W       (IDX_W),
      .OFS_W       (OFS_W),
      .ENTRY_BYTES (ENTRY_BYTES)
   ) u_addr (
      .sel_tbl   (sel_tbl),
      .dir_base  (dbase_q),
      .tbl_frame (tframe_q),
      .dir_idx   (idx[0]),
      .tbl_idx   (idx[1]),
      .addr      (mem_addr)
   );

   assign req_ready   = (state_q == ST_IDLE);
   assign mem_rd      = (state_q == ST_DIR_RD) || (state_q == ST_TBL_RD);
   assign fault_vaddr = va_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q     <= ST_IDLE;
         va_q        <= '0;
         dbase_q     <= '0;
         tframe_q    <= '0;
         done_valid  <= 1'b0;
         done_paddr  <= '0;
         fault_valid <= 1'b0;
         fault_level <= 1'b0;
      end else begin
         done_valid  <= 1'b0;
         fault_valid <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (req_valid) begin
                  va_q    <= req_vaddr;
                  dbase_q <= req_dirbase;
                  state_q <= ST_DIR_RD;
               end
            end
            ST_DIR_RD: state_q <= ST_DIR_WT;
            ST_DIR_WT: begin
               if (mem_rsp_valid) begin
                  if (rsp_present) begin
                     tframe_q <= rsp_frame;
                     state_q  <= ST_TBL_RD;
                  end else begin
                     fault_valid <= 1'b1;
                     fault_level <= LVL_DIR;
                     state_q     <= ST_IDLE;
                  end
               end
            end
            ST_TBL_RD: state_q <= ST_TBL_WT;
            ST_TBL_WT: begin
               if (mem_rsp_valid) begin
                  if (rsp_present) begin
                     done_valid <= 1'b1;
                     done_paddr <= {rsp_frame, ofs};
                  end else begin
                     fault_valid <= 1'b1;
                     fault_level <= LVL_TBL;
                  end
                  state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // R8: only one kind of outcome per cycle
   assert_single_outcome_R8: assert property (@(posedge clk) disable iff (rst)
      !(done_valid && fault_valid));

   // R9: acceptance drops ready on the next cycle
   assert_busy_after_accept_R9: assert property (@(posedge clk) disable iff (rst)
      (req_valid && req_ready) |=> !req_ready);

   // R10: each read strobe lasts a single cycle
   assert_read_pulse_R10: assert property (@(posedge clk) disable iff (rst)
      mem_rd |=> !mem_rd);

   // R9: no read while idle
   assert_idle_no_read_R9: assert property (@(posedge clk) disable iff (rst)
      req_ready |-> !mem_rd);

   // R3: present directory slot leads to the table read next cycle
   assert_table_read_R3: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_DIR_WT && mem_rsp_valid && rsp_present) |=> mem_rd);

   // R5: absent directory slot faults at level 0 without another read
   assert_dir_fault_R5: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_DIR_WT && mem_rsp_valid && !rsp_present)
      |=> (fault_valid && fault_level == LVL_DIR && !mem_rd));

   // R4: success pulse only after a present table slot
   assert_done_source_R4: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_TBL_WT && mem_rsp_valid && rsp_present) |=> done_valid);
endmodule

// File: tb/xlate_walker_tb.sv
`timescale 1ns/1ps
module xlate_walker_tb;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [25:0] req_vaddr = '0;
   logic [31:0] req_dirbase = '0;
   logic        mem_rd;
   logic [31:0] mem_addr;
   logic        mem_rsp_valid = 1'b0;
   logic [31:0] mem_rsp_data = '0;
   logic        done_valid;
   logic [31:0] done_paddr;
   logic        fault_valid;
   logic        fault_level;
   logic [25:0] fault_vaddr;

   always #4 clk = ~clk;

   xlate_walker u_dut (
      .clk(clk), .rst(rst),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_vaddr(req_vaddr), .req_dirbase(req_dirbase),
      .mem_rd(mem_rd), .mem_addr(mem_addr),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
      .done_valid(done_valid), .done_paddr(done_paddr),
      .fault_valid(fault_valid), .fault_level(fault_level),
      .fault_vaddr(fault_vaddr)
   );

   logic [31:0] wmem [0:4095];
   int          checks = 0;
   int          fails = 0;
   int          max_wait = 3;
   bit          finished = 1'b0;

   // memory responder
   int          rd_cnt = 0;
   logic [31:0] rd_last = '0;
   logic [31:0] rd_prev = '0;
   initial begin
      forever begin
         @(posedge clk);
         if (mem_rd) begin
            logic [31:0] a;
            int w;
            a = mem_addr;
            rd_prev = rd_last;
            rd_last = a;
            rd_cnt++;
            w = $urandom_range(0, max_wait);
            repeat (w) @(posedge clk);
            #1;
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = wmem[a[13:2]];
            @(posedge clk);
            #1;
            mem_rsp_valid = 1'b0;
            mem_rsp_data  = $urandom;
         end
      end
   end

   // port monitor
   int both_bad = 0;
   int rd_pulse_bad = 0;
   logic prev_rd = 1'b0;
   always @(negedge clk) begin
      if (!rst) begin
         if (done_valid && fault_valid) both_bad++;
         if (mem_rd && prev_rd) rd_pulse_bad++;
      end
      prev_rd = mem_rd && !rst;
   end

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // kind: 0 done, 1 directory fault, 2 table fault
   function automatic void exp_walk(input logic [25:0] va, input logic [31:0] base,
                                    output int kind, output logic [31:0] pa, output int nrd,
                                    output logic [31:0] a0, output logic [31:0] a1);
      logic [31:0] de;
      logic [31:0] pe;
      a0 = base + {22'd0, va[25:18], 2'b00};
      de = wmem[a0[13:2]];
      a1 = {de[31:10], 10'd0} + {22'd0, va[17:10], 2'b00};
      pa = '0;
      if (!de[0]) begin
         kind = 1; nrd = 1;
      end else begin
         nrd = 2;
         pe = wmem[a1[13:2]];
         if (!pe[0]) kind = 2;
         else begin
            kind = 0;
            pa = {pe[31:10], va[9:0]};
         end
      end
   endfunction

   task automatic run_walk(input logic [25:0] va, input logic [31:0] base, input bit noise);
      int kind, nrd, got_kind, n, start_cnt, busy_bad;
      logic [31:0] pa, a0, a1, got_pa;
      logic [25:0] got_fva;
      bit got;
      exp_walk(va, base, kind, pa, nrd, a0, a1);
      start_cnt = rd_cnt;
      @(negedge clk);
      chk(req_ready == 1'b1, "R9 ready before request", 64'(req_ready), 64'd1);
      req_valid = 1'b1; req_vaddr = va; req_dirbase = base;
      @(posedge clk);
      #1;
      if (noise) begin
         req_vaddr = ~va; req_dirbase = base ^ 32'h400;
      end else req_valid = 1'b0;
      got = 1'b0; busy_bad = 0; n = 0; got_kind = -1; got_pa = '0; got_fva = '0;
      while (!got && n < 200) begin
         @(negedge clk);
         n++;
         if (done_valid || fault_valid) begin
            got = 1'b1;
            got_kind = done_valid ? 0 : (fault_level ? 2 : 1);
            got_pa = done_paddr;
            got_fva = fault_vaddr;
            req_valid = 1'b0;
         end else if (req_ready) busy_bad++;
      end
      chk(got, "R8 outcome pulse seen", 64'(got), 64'd1);
      chk(busy_bad == 0, "R9 ready low while busy", 64'(busy_bad), 64'd0);
      chk(got_kind == kind, "R5 R6 outcome kind", 64'(got_kind), 64'(kind));
      if (kind == 0) chk(got_pa == pa, "R4 physical address", 64'(got_pa), 64'(pa));
      else chk(got_fva == va, "R5 R6 fault vaddr", 64'(got_fva), 64'(va));
      if (nrd == 2) begin
         chk(rd_prev == a0, "R2 directory slot address", 64'(rd_prev), 64'(a0));
         chk(rd_last == a1, "R3 table slot address", 64'(rd_last), 64'(a1));
      end else
         chk(rd_last == a0, "R2 directory slot address", 64'(rd_last), 64'(a0));
      @(negedge clk);
      chk(!done_valid && !fault_valid, "R8 single-cycle pulse", 64'({done_valid, fault_valid}), 64'd0);
      @(negedge clk);
      chk(rd_cnt - start_cnt == nrd, "R5 read count", 64'(rd_cnt - start_cnt), 64'(nrd));
   endtask

   // builds a walk; dmode/tmode: 1 = present
   task automatic build(input logic [25:0] va, input int bp, input bit dpres, input bit tpres,
                        input logic [21:0] frame);
      int tp;
      tp = $urandom_range(4, 15);
      wmem[bp*256 + int'(va[25:18])] = {22'(tp), 9'($urandom_range(0, 511)), dpres};
      wmem[tp*256 + int'(va[17:10])] = {frame, 9'($urandom_range(0, 511)), tpres};
   endtask

   initial begin
      void'($urandom(32'd20240611));
      for (int i = 0; i < 4096; i++) wmem[i] = $urandom & 32'hFFFF_FFFE;
      repeat (3) @(posedge clk);
      #1 rst = 1'b0;
      @(negedge clk);
      chk(req_ready && !done_valid && !fault_valid && !mem_rd, "R1 reset state",
          64'({req_ready, done_valid, fault_valid, mem_rd}), 64'b1000);

      // directed: all-zero address, present both levels
      build(26'h0, 0, 1'b1, 1'b1, 22'h3FFFFF);
      run_walk(26'h0, 32'h0, 1'b0);
      // directed: all-one address, max frame and offset
      build(26'h3FFFFFF, 1, 1'b1, 1'b1, 22'h3FFFFF);
      run_walk(26'h3FFFFFF, 32'h400, 1'b0);
      // directed: directory absent (R5) and table absent (R6)
      build(26'h12_3456, 2, 1'b0, 1'b1, 22'h1);
      run_walk(26'h12_3456, 32'h800, 1'b0);
      build(26'h2A_BCDE, 3, 1'b1, 1'b0, 22'h2);
      run_walk(26'h2A_BCDE, 32'hC00, 1'b0);
      // R7: reserved bits all set, present
      wmem[0*256 + 8'h55] = {22'd9, 9'h1FF, 1'b1};
      wmem[9*256 + 8'hAA] = {22'h15A5A, 9'h1FF, 1'b1};
      run_walk({8'h55, 8'hAA, 10'h2C3}, 32'h0, 1'b0);
      // R7: reserved bits all set, absent at directory
      wmem[0*256 + 8'h56] = {22'd9, 9'h1FF, 1'b0};
      run_walk({8'h56, 8'hAA, 10'h001}, 32'h0, 1'b0);
      // R9: request held high during the walk
      build(26'h1F_0F0F, 1, 1'b1, 1'b1, 22'h0ABCD);
      run_walk(26'h1F_0F0F, 32'h400, 1'b1);
      // R10: long memory latency
      max_wait = 12;
      build(26'h0C_1234, 2, 1'b1, 1'b1, 22'h22222);
      run_walk(26'h0C_1234, 32'h800, 1'b0);
      max_wait = 3;

      // random walks (R2 R3 R4 R5 R6 R7 R10)
      for (int t = 0; t < 80; t++) begin
         logic [25:0] va;
         int bp, r;
         va = 26'($urandom);
         bp = $urandom_range(0, 3);
         r  = $urandom_range(0, 9);
         build(va, bp, r >= 2, r >= 4, 22'($urandom));
         run_walk(va, 32'(bp) << 10, (t % 7) == 0);
      end

      // R11: reset in the middle of a walk
      max_wait = 6;
      build(26'h33_3333, 0, 1'b1, 1'b1, 22'h11111);
      @(negedge clk);
      req_valid = 1'b1; req_vaddr = 26'h33_3333; req_dirbase = 32'h0;
      @(negedge clk);
      req_valid = 1'b0;
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk(req_ready && !done_valid && !fault_valid && !mem_rd, "R11 idle after reset",
          64'({req_ready, done_valid, fault_valid, mem_rd}), 64'b1000);
      begin
         int stray;
         stray = 0;
         repeat (14) begin
            @(negedge clk);
            if (done_valid || fault_valid || mem_rd || !req_ready) stray++;
         end
         chk(stray == 0, "R11 late response ignored", 64'(stray), 64'd0);
      end
      max_wait = 3;
      build(26'h33_3333, 0, 1'b1, 1'b1, 22'h11111);
      run_walk(26'h33_3333, 32'h0, 1'b0);

      chk(both_bad == 0, "R8 done and fault together", 64'(both_bad), 64'd0);
      chk(rd_pulse_bad == 0, "R10 read strobe width", 64'(rd_pulse_bad), 64'd0);

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks + 1, fails + 1);
         $finish;
      end
   end
endmodule